// File: doc/BRIEF.md
# Programmable-Increment System Time Counter

This block keeps a free-running 64-bit time value for packet timestamping. The value is held in fixed point: the low 19 bits are fractions of a nanosecond and the bits above them count whole nanoseconds. A base tick strobe drives the counter. After a programmable number of base ticks, it adds a programmable increment of up to 24 bits. A small rate correction therefore shows up on every period, not only as an occasional whole-nanosecond step.

Software reaches the counter through a 32-bit register bus. A bus cycle has a 2-bit word address, a write strobe, a read strobe and a registered read-data return one cycle later. The 64-bit time is accessed as two words, always low word first.
- Reading the low word copies the high half of the same instant into a shadow. The following high-word read returns that shadow, so the two halves always belong together.
- Writing the low word only stages it. Writing the high word then commits both halves in a single cycle.
- A pause bit freezes counting while software loads a new time.

The counter wraps modulo 2^64. A value preloaded just below the top rolls over to small values on the next addition.

The word addresses are:

| Address | Word |
|---|---|
| 0 | Time, low word |
| 1 | Time, high word |
| 2 | Rate: increment in bits [23:0], period in bits [31:24] |
| 3 | Control: pause in bit 31 |

The load sequencer is a two-state machine:
- **LD_IDLE**: nothing is staged. A low-word write takes the transition *stage* to LD_STAGED. A high-word write is ignored.
- **LD_STAGED**: a low word is held. Another low-word write takes the transition *restage* and stays here with the new value. A high-word write takes the transition *commit*: it loads the full value and returns to LD_IDLE.

Top module: `systime_counter`

## Requirements
- R1: After reset the time is 0, the rate word reads 0, the control word reads 0 and the sequencer is in LD_IDLE. With an increment of 0, base ticks leave the time at 0.
- R2: A rate word with period field 1 and increment 0x800000 (16 shifted left by 19) adds 16 whole nanoseconds to bits [63:19] of the time on each base tick.
- R3: With period field P (bits [31:24]) and increment I (bits [23:0]), the time grows by exactly I on every P-th unpaused base tick and not at all on the ticks between. A period of 0 or 1 means every tick.
- R4: A low-word write (address 0) stages its data without changing the time. A following high-word write (address 1) loads {high, staged low} in one cycle, and any counting between the two writes is discarded. A second low-word write before the high-word write replaces the staged value.
- R5: Setting control bit 31 (address 3) stops the counter and the period count. Clearing it restarts counting from the value held, with the period count starting from zero.
- R6: While the counter is running, a rate write takes effect only after the period in progress completes. That completing addition uses the old increment and old period. While the counter is paused, a rate write takes effect at once.
- R7: The time wraps modulo 2^64 with no saturation.
- R8: A low-word read (address 0) returns the live low word and latches the live high word. A high-word read (address 1) returns the latched word even if the counter has moved since.
- R9: A high-word read with no low-word read before it returns the last latched high word again.
- R10: A high-word write while the sequencer is in LD_IDLE is ignored and leaves the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base tick strobe, one clock wide per tick |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |

## Verification
The bench reads the low word, then runs enough ticks to carry into the high half, and reads the high word again without a low-word read. A design that reads the live high word there returns a value one greater than the latched one. It moves the counter between a staged low-word write and the commit, and sends a lone high-word write. A design that loads word by word, or one that accepts a high word with nothing staged, leaves a mixed or altered time. It changes the rate halfway through a four-tick period and preloads a value just below 2^64. An early rate switch adds the wrong increment, and a saturating counter sticks at the top instead of rolling over to 0x400000.

// File: rtl/systime_pkg.sv
package systime_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_TIME_LO = 2'd0,
        REG_TIME_HI = 2'd1,
        REG_RATE    = 2'd2,
        REG_CTRL    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LD_IDLE   = 1'b0,
        LD_STAGED = 1'b1
    } load_state_e;

endpackage

// File: rtl/systime_rate_gen.sv
module systime_rate_gen #(
    parameter int unsigned INC_W = 24,
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             pause,
    input  logic [INC_W-1:0] pend_inc,
    input  logic [PER_W-1:0] pend_per,
    output logic             add_pulse,
    output logic [INC_W-1:0] add_inc
);

    logic [PER_W-1:0] cnt_q;
    logic [INC_W-1:0] inc_act_q;
    logic [PER_W-1:0] per_act_q;
    logic [PER_W:0]   cnt_next;
    logic             period_done;

    always_comb begin
        cnt_next    = {1'b0, cnt_q} + 1'b1;
        period_done = base_tick && !pause && (cnt_next >= {1'b0, per_act_q});
        add_pulse   = period_done;
        add_inc     = inc_act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            inc_act_q <= '0;
            per_act_q <= '0;
        end else if (pause || period_done) begin
            cnt_q     <= '0;
            inc_act_q <= pend_inc;
            per_act_q <= pend_per;
        end else if (base_tick) begin
            cnt_q <= cnt_next[PER_W-1:0];
        end
    end

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_tick || pause) |-> !add_pulse); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q < per_act_q)); // R3
    AST_PAUSE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/systime_core.sv
module systime_core #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned INC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_pulse,
    input  logic [INC_W-1:0]  add_inc,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_now
);

    localparam int unsigned PAD_W = TIME_W - INC_W;

    logic [TIME_W-1:0] time_q;
    logic [TIME_W-1:0] step;

    always_comb begin
        step     = {{PAD_W{1'b0}}, add_inc};
        time_now = time_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (load_en) begin
            time_q <= load_val;
        end else if (add_pulse) begin
            time_q <= time_q + step;
        end
    end

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_q == $past(load_val))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !add_pulse) |=> (time_q == $past(time_q))); // R5
    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (add_pulse && !load_en) |=> (time_q == $past(time_q) + {{PAD_W{1'b0}}, $past(add_inc)})); // R7

endmodule

// File: rtl/systime_regif.sv
module systime_regif
    import systime_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned INC_W  = 24,
    parameter int unsigned PER_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [2*DATA_W-1:0]   time_now,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  pause,
    output logic [INC_W-1:0]      pend_inc,
    output logic [PER_W-1:0]      pend_per,
    output logic                  load_en,
    output logic [2*DATA_W-1:0]   load_val
);

    localparam int unsigned PAUSE_BIT = DATA_W - 1;

    load_state_e      state_q, state_d;
    reg_sel_e         sel;
    logic             wr_lo, wr_hi, wr_rate, wr_ctrl;
    logic [DATA_W-1:0] staged_lo_q;
    logic [DATA_W-1:0] shadow_hi_q;
    logic [DATA_W-1:0] rate_word, ctrl_word;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        wr_lo   = bus_we && (sel == REG_TIME_LO);
        wr_hi   = bus_we && (sel == REG_TIME_HI);
        wr_rate = bus_we && (sel == REG_RATE);
        wr_ctrl = bus_we && (sel == REG_CTRL);
    end

    // Load sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:   if (wr_lo) state_d = LD_STAGED;
            LD_STAGED: if (wr_hi) state_d = LD_IDLE;
            default:   state_d = LD_IDLE;
        endcase
    end

    // Load sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // Load sequencer: outputs
    always_comb begin
        load_en  = 1'b0;
        load_val = {bus_wdata, staged_lo_q};
        unique case (state_q)
            LD_IDLE:   load_en = 1'b0;
            LD_STAGED: load_en = wr_hi;
            default:   load_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_lo_q <= '0;
            pend_inc    <= '0;
            pend_per    <= '0;
            pause       <= 1'b0;
        end else begin
            if (wr_lo) staged_lo_q <= bus_wdata;
            if (wr_rate) begin
                pend_inc <= bus_wdata[INC_W-1:0];
                pend_per <= bus_wdata[INC_W +: PER_W];
            end
            if (wr_ctrl) pause <= bus_wdata[PAUSE_BIT];
        end
    end

    always_comb begin
        rate_word                 = '0;
        rate_word[INC_W-1:0]      = pend_inc;
        rate_word[INC_W +: PER_W] = pend_per;
        ctrl_word                 = '0;
        ctrl_word[PAUSE_BIT]      = pause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            shadow_hi_q <= '0;
        end else if (bus_re) begin
            unique case (sel)
                REG_TIME_LO: begin
                    bus_rdata   <= time_now[DATA_W-1:0];
                    shadow_hi_q <= time_now[2*DATA_W-1:DATA_W];
                end
                REG_TIME_HI: bus_rdata <= shadow_hi_q;
                REG_RATE:    bus_rdata <= rate_word;
                REG_CTRL:    bus_rdata <= ctrl_word;
                default:     bus_rdata <= '0;
            endcase
        end
    end

    AST_STAGE_FROM_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LD_STAGED) |-> $past(wr_lo)); // R4
    AST_HI_READ_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == REG_TIME_HI) |=> (bus_rdata == shadow_hi_q)); // R8
    AST_LONE_HI_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE) |-> !load_en); // R10

endmodule

// File: rtl/systime_counter.sv
module systime_counter
    import systime_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned INC_W  = 24,
    parameter int unsigned PER_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  base_tick,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [DATA_W-1:0]     bus_rdata
);

    localparam int unsigned TIME_W = 2 * DATA_W;

    logic              pause;
    logic [INC_W-1:0]  pend_inc;
    logic [PER_W-1:0]  pend_per;
    logic              load_en;
    logic [TIME_W-1:0] load_val;
    logic [TIME_W-1:0] time_now;
    logic              add_pulse;
    logic [INC_W-1:0]  add_inc;

    systime_regif #(.DATA_W(DATA_W), .INC_W(INC_W), .PER_W(PER_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re),
        .time_now(time_now), .bus_rdata(bus_rdata),
        .pause(pause), .pend_inc(pend_inc), .pend_per(pend_per),
        .load_en(load_en), .load_val(load_val)
    );

    systime_rate_gen #(.INC_W(INC_W), .PER_W(PER_W)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .base_tick(base_tick), .pause(pause),
        .pend_inc(pend_inc), .pend_per(pend_per),
        .add_pulse(add_pulse), .add_inc(add_inc)
    );

    systime_core #(.TIME_W(TIME_W), .INC_W(INC_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .add_pulse(add_pulse), .add_inc(add_inc),
        .load_en(load_en), .load_val(load_val),
        .time_now(time_now)
    );

endmodule

// File: tb/test_systime_counter.sv
module test_systime_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    systime_counter i_systime_counter (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        t = {hi, lo};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        base_tick = 1'b1;
        repeat (n) @(negedge clk);
        base_tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        logic [63:0] t;
        rd_time(t);   check("R1 time", t, 64'h0);
        rd(2'd2, d);  check("R1 rate", {32'h0, d}, 64'h0);
        rd(2'd3, d);  check("R1 ctrl", {32'h0, d}, 64'h0);
        ticks(5);
        rd_time(t);   check("R1 zero increment", t, 64'h0);
    endtask

    task automatic t_nominal;
        logic [63:0] t;
        wr(2'd2, {8'd1, 24'h800000});
        ticks(1);
        rd_time(t); check("R6 first tick uses old rate", t, 64'h0);
        ticks(1);
        rd_time(t); check("R2 nominal step", t, 64'h800000);
        check("R2 integer ns", {19'h0, t[63:19]}, 64'd16);
    endtask

    task automatic t_period;
        logic [63:0] t;
        wr(2'd2, {8'd4, 24'd5});
        ticks(1);
        rd_time(t); check("R6 old rate completes", t, 64'h1000000);
        ticks(3);
        rd_time(t); check("R3 no add mid period", t, 64'h1000000);
        ticks(1);
        rd_time(t); check("R3 add at period end", t, 64'h1000005);
        ticks(8);
        rd_time(t); check("R3 two periods", t, 64'h100000F);
    endtask

    task automatic t_pause_load;
        logic [31:0] d;
        logic [63:0] t;
        wr(2'd3, 32'h8000_0000);
        rd(2'd3, d); check("R5 ctrl readback", {32'h0, d}, 64'h8000_0000);
        wr(2'd0, 32'hFFC0_0000);
        ticks(4);
        rd_time(t); check("R4 staged low has no effect", t, 64'h100000F);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_time(t); check("R4 commit", t, 64'hFFFF_FFFF_FFC0_0000);
        ticks(10);
        rd_time(t); check("R5 paused holds", t, 64'hFFFF_FFFF_FFC0_0000);
    endtask

    task automatic t_wrap;
        logic [63:0] t;
        wr(2'd2, {8'd1, 24'h800000});
        wr(2'd3, 32'h0);
        ticks(1);
        rd_time(t); check("R7 wrap", t, 64'h0000_0000_0040_0000);
    endtask

    task automatic t_coherent;
        logic [31:0] d;
        rd(2'd0, d); check("R8 low read", {32'h0, d}, 64'h0040_0000);
        ticks(512);
        rd(2'd1, d); check("R8 high from shadow", {32'h0, d}, 64'h0);
        rd(2'd1, d); check("R9 repeated high", {32'h0, d}, 64'h0);
        rd(2'd0, d); check("R8 new low", {32'h0, d}, 64'h0040_0000);
        rd(2'd1, d); check("R8 new high", {32'h0, d}, 64'h1);
    endtask

    task automatic t_load_order;
        logic [63:0] t;
        wr(2'd1, 32'h0000_ABCD);
        rd_time(t); check("R10 lone high ignored", t, 64'h1_0040_0000);
        wr(2'd0, 32'h0000_1111);
        wr(2'd0, 32'h0000_2222);
        ticks(3);
        wr(2'd1, 32'h0000_0003);
        rd_time(t); check("R4 restage and commit", t, 64'h3_0000_2222);
    endtask

    task automatic t_rate_boundary;
        logic [63:0] t;
        wr(2'd2, {8'd4, 24'h10});
        ticks(1);
        rd_time(t); check("R6 swap at boundary", t, 64'h3_0080_2222);
        ticks(2);
        wr(2'd2, {8'd1, 24'h1000});
        ticks(1);
        rd_time(t); check("R6 mid period no add", t, 64'h3_0080_2222);
        ticks(1);
        rd_time(t); check("R6 old increment", t, 64'h3_0080_2232);
        ticks(1);
        rd_time(t); check("R6 new increment", t, 64'h3_0080_3232);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nominal();
        t_period();
        t_pause_load();
        t_wrap();
        t_coherent();
        t_load_order();
        t_rate_boundary();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule